// File: doc/BRIEF.md
# Received-Sample Gate and Formatter for a Two-Channel Digital Audio Receiver

This block sits behind a biphase-mark line decoder. Each decoded subframe arrives as a one-cycle strobe carrying a 24-bit audio word, four trailing flag bits (validity, user, channel status, parity) and a start-of-block marker. A mode word controls three things: whether the subframe is accepted, how the audio is cut to the chosen width, and how it is ordered and optionally packed into a 32-bit holding word. The block keeps a ready flag, an overrun flag and a parity-error flag for a reader that drains the holding word.

Every decision is registered once. The holding word and the flags change on the clock edge that samples the subframe strobe. A holding-read strobe clears ready. A status-read strobe clears the two error flags. A software-reset strobe clears all datapath state without touching the mode word.

Top module: `spdif_sample_fmt`

## Requirements
- R1: With mode bit 0 (receiver on) clear, a subframe changes neither the holding word nor any flag, and it drops any half-filled packed word.
- R2: With mode bit 1 clear, subframes load whatever their validity bit. With it set, a subframe whose validity bit is 1 is discarded.
- R3: Parity is even over the 24 audio bits together with the validity, user, channel-status and parity bits. With mode bit 3 clear, a subframe of odd parity is discarded and raises the parity-error flag. With mode bit 3 set, parity is ignored and the subframe loads.
- R4: Mode bits 5:4 pick the width: 0 gives 24 bits (the whole audio word), 1 gives 20 bits (audio[23:4]), 2 or 3 give 16 bits (audio[23:8]). The chosen bits sit right-justified in the holding word, with zeros above them.
- R5: Mode bit 2 set reverses the byte order inside the occupied bytes: three bytes for 20 and 24 bits, two bytes for 16 bits. Clear leaves the order unchanged.
- R6: Mode bit 6 with a 16-bit width packs two accepted samples into one holding word: the first in bits 15:0, the second in bits 31:16, loaded when the second arrives. At 20 or 24 bits, mode bit 6 has no effect.
- R7: Mode bit 7 set discards a subframe that carries the start-of-block marker. Clear loads it.
- R8: A load sets ready in the next cycle. A holding read clears ready. When a load and a holding read fall in the same cycle, ready stays set.
- R9: A load while ready is set and no holding read is present sets the overrun flag and overwrites the holding word. Overrun stays set until a status read.
- R10: The parity-error flag stays set through later good subframes until a status read.
- R11: A software-reset strobe clears the holding word, ready, overrun, parity error and any half-filled packed word.
- R12: After reset, the holding word and all flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 8 | Mode word (bit meanings in R1 to R7) |
| soft_rst_i | input | 1 | Software-reset strobe |
| sf_valid_i | input | 1 | Subframe strobe, one cycle per subframe |
| sf_audio_i | input | 24 | Audio word, MSB in bit 23 |
| sf_v_i | input | 1 | Validity bit |
| sf_u_i | input | 1 | User bit |
| sf_c_i | input | 1 | Channel-status bit |
| sf_p_i | input | 1 | Parity bit |
| sf_blk_i | input | 1 | Start-of-block marker |
| hold_rd_i | input | 1 | Holding-word read strobe |
| stat_rd_i | input | 1 | Status read strobe |
| hold_data_o | output | 32 | Holding word |
| ready_o | output | 1 | Holding word loaded and unread |
| overrun_o | output | 1 | Sticky overrun flag |
| par_err_o | output | 1 | Sticky parity-error flag |

## Verification
The assertions assume that the subframe fields are meaningful only while the strobe is high, and that the mode word does not change in the same cycle as a strobe. The bench writes the mode word at a falling edge one full cycle before the subframe it governs. It also sets the parity bit from its own even-parity rule, flipping it only where a vector asks for a parity error. Read and reset strobes last exactly one cycle and are driven at falling edges, so each sampling edge sees a settled input.

// File: rtl/spdif_fmt_pkg.sv
package spdif_fmt_pkg;
  localparam int AUDIO_W = 24;
  localparam int HOLD_W  = 32;
  localparam int HALF_W  = HOLD_W / 2;

  typedef struct packed {
    logic       drop_blk;
    logic       pack_en;
    logic [1:0] width_code;
    logic       skip_par;
    logic       big_end;
    logic       drop_inval;
    logic       rx_on;
  } mode_t;

  // odd result means a parity mismatch
  function automatic logic parity_odd(input logic [AUDIO_W-1:0] audio,
                                      input logic v, input logic u,
                                      input logic c, input logic p);
    return ^{audio, v, u, c, p};
  endfunction

  // right-justify the selected top bits of the audio word
  function automatic logic [AUDIO_W-1:0] fmt_align(input logic [AUDIO_W-1:0] audio,
                                                   input logic [1:0] code);
    logic [AUDIO_W-1:0] r;
    case (code)
      2'd0:    r = audio;
      2'd1:    r = {4'b0, audio[AUDIO_W-1:4]};
      default: r = {8'b0, audio[AUDIO_W-1:8]};
    endcase
    return r;
  endfunction

  // byte order within the occupied bytes
  function automatic logic [HOLD_W-1:0] fmt_order(input logic [AUDIO_W-1:0] s,
                                                  input logic [1:0] code,
                                                  input logic big);
    logic [HOLD_W-1:0] r;
    if (!big)          r = {8'b0, s};
    else if (code[1])  r = {16'b0, s[7:0], s[15:8]};
    else               r = {8'b0, s[7:0], s[15:8], s[23:16]};
    return r;
  endfunction
endpackage

// File: rtl/sf_accept.sv
module sf_accept
  import spdif_fmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  mode_t              mode,
  input  logic               sf_valid,
  input  logic [AUDIO_W-1:0] audio,
  input  logic               v,
  input  logic               u,
  input  logic               c,
  input  logic               p,
  input  logic               blk,
  output logic               take_o,
  output logic               par_bad_o
);
  logic odd;
  logic live;
  logic reject;

  always_comb begin
    odd       = parity_odd(audio, v, u, c, p);
    live      = sf_valid && mode.rx_on;
    par_bad_o = live && !mode.skip_par && odd;
    reject    = (mode.drop_inval && v) || (mode.drop_blk && blk) || par_bad_o;
    take_o    = live && !reject;
  end

  // R3: a flagged parity error never coincides with an accepted sample
  p_par_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    par_bad_o |-> !take_o);
  // R7: a marked block start under drop mode is not taken
  p_blk_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_valid && mode.drop_blk && blk) |-> !take_o);
endmodule

// File: rtl/sf_shaper.sv
module sf_shaper
  import spdif_fmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  mode_t              mode,
  input  logic               take,
  input  logic [AUDIO_W-1:0] audio,
  output logic               load_o,
  output logic [HOLD_W-1:0]  word_o
);
  logic              half_q;
  logic [HALF_W-1:0] low_q;
  logic              pack_active;
  logic [HOLD_W-1:0] fmt;

  always_comb begin
    pack_active = mode.pack_en && mode.width_code[1];
    fmt         = fmt_order(fmt_align(audio, mode.width_code), mode.width_code, mode.big_end);
    load_o      = take && !clr && (!pack_active || half_q);
    word_o      = pack_active ? {fmt[HALF_W-1:0], low_q} : fmt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      low_q  <= '0;
    end else if (clr || !pack_active) begin
      half_q <= 1'b0;
    end else if (take) begin
      half_q <= !half_q;
      if (!half_q) low_q <= fmt[HALF_W-1:0];
    end
  end

  // R6: first half of a packed pair is held back, not loaded
  p_pack_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pack_active && !half_q && !clr) |=> (half_q && !load_o));
  // R11: clearing drops any pending half
  p_clr_half_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !half_q);
endmodule

// File: rtl/sf_holdreg.sv
module sf_holdreg
  import spdif_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [HOLD_W-1:0] word,
  input  logic              par_bad,
  input  logic              hold_rd,
  input  logic              stat_rd,
  output logic [HOLD_W-1:0] hold_o,
  output logic              ready_o,
  output logic              overrun_o,
  output logic              par_err_o
);
  logic overrun_ev;

  assign overrun_ev = load && ready_o && !hold_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_o    <= '0;
      ready_o   <= 1'b0;
      overrun_o <= 1'b0;
      par_err_o <= 1'b0;
    end else if (clr) begin
      hold_o    <= '0;
      ready_o   <= 1'b0;
      overrun_o <= 1'b0;
      par_err_o <= 1'b0;
    end else begin
      if (load) hold_o <= word;
      ready_o   <= load || (ready_o && !hold_rd);
      overrun_o <= overrun_ev || (overrun_o && !stat_rd);
      par_err_o <= par_bad || (par_err_o && !stat_rd);
    end
  end

  p_ready_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> ready_o);
  p_ready_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rd && !load && !clr) |=> !ready_o);
  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ready_o && !hold_rd && !clr) |=> overrun_o);
  p_perr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_o && !stat_rd && !clr) |=> par_err_o);
  p_swrst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ready_o && !overrun_o && !par_err_o && hold_o == '0));
endmodule

// File: rtl/spdif_sample_fmt.sv
module spdif_sample_fmt
  import spdif_fmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         mode_i,
  input  logic               soft_rst_i,
  input  logic               sf_valid_i,
  input  logic [AUDIO_W-1:0] sf_audio_i,
  input  logic               sf_v_i,
  input  logic               sf_u_i,
  input  logic               sf_c_i,
  input  logic               sf_p_i,
  input  logic               sf_blk_i,
  input  logic               hold_rd_i,
  input  logic               stat_rd_i,
  output logic [HOLD_W-1:0]  hold_data_o,
  output logic               ready_o,
  output logic               overrun_o,
  output logic               par_err_o
);
  mode_t             mode;
  logic              take_ev;
  logic              par_bad_ev;
  logic              load_ev;
  logic              shape_clr;
  logic [HOLD_W-1:0] shaped_word;

  assign mode      = mode_t'(mode_i);
  assign shape_clr = soft_rst_i || !mode.rx_on;

  sf_accept u_accept (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sf_valid(sf_valid_i),
    .audio(sf_audio_i), .v(sf_v_i), .u(sf_u_i), .c(sf_c_i), .p(sf_p_i),
    .blk(sf_blk_i), .take_o(take_ev), .par_bad_o(par_bad_ev)
  );

  sf_shaper u_shaper (
    .clk(clk), .rst_n(rst_n), .clr(shape_clr), .mode(mode), .take(take_ev),
    .audio(sf_audio_i), .load_o(load_ev), .word_o(shaped_word)
  );

  sf_holdreg u_hold (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst_i), .load(load_ev),
    .word(shaped_word), .par_bad(par_bad_ev), .hold_rd(hold_rd_i),
    .stat_rd(stat_rd_i), .hold_o(hold_data_o), .ready_o(ready_o),
    .overrun_o(overrun_o), .par_err_o(par_err_o)
  );

  // R1: a receiver that is off raises nothing
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.rx_on && !soft_rst_i) |=> (!$rose(ready_o) && !$rose(overrun_o) && !$rose(par_err_o)));
  // R2: an invalid-marked subframe under discard mode leaves the holding word alone
  p_inval_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_valid_i && mode.drop_inval && sf_v_i && !soft_rst_i) |=> $stable(hold_data_o));
endmodule

// File: tb/tb_spdif_sample_fmt.sv
module tb_spdif_sample_fmt;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mode_i = '0;
  logic        soft_rst_i = 1'b0;
  logic        sf_valid_i = 1'b0;
  logic [23:0] sf_audio_i = '0;
  logic        sf_v_i = 1'b0, sf_u_i = 1'b0, sf_c_i = 1'b0, sf_p_i = 1'b0, sf_blk_i = 1'b0;
  logic        hold_rd_i = 1'b0, stat_rd_i = 1'b0;
  logic [31:0] hold_data_o;
  logic        ready_o, overrun_o, par_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spdif_sample_fmt dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .soft_rst_i(soft_rst_i),
    .sf_valid_i(sf_valid_i), .sf_audio_i(sf_audio_i), .sf_v_i(sf_v_i),
    .sf_u_i(sf_u_i), .sf_c_i(sf_c_i), .sf_p_i(sf_p_i), .sf_blk_i(sf_blk_i),
    .hold_rd_i(hold_rd_i), .stat_rd_i(stat_rd_i), .hold_data_o(hold_data_o),
    .ready_o(ready_o), .overrun_o(overrun_o), .par_err_o(par_err_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [7:0]  mode;
    logic [23:0] audio;
    logic        v, u, c, blk, badp;
    logic        ld;
    logic [31:0] word;
    logic        pe;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd4, 8'h01, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h00A1B2C3, 1'b0}, // R4 24-bit
    '{4'd4, 8'h11, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h000A1B2C, 1'b0}, // R4 20-bit
    '{4'd4, 8'h21, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h0000A1B2, 1'b0}, // R4 16-bit
    '{4'd4, 8'h31, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h0000A1B2, 1'b0}, // R4 code 3
    '{4'd5, 8'h05, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h00C3B2A1, 1'b0}, // R5 big 24
    '{4'd5, 8'h25, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h0000B2A1, 1'b0}, // R5 big 16
    '{4'd5, 8'h15, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h002C1B0A, 1'b0}, // R5 big 20
    '{4'd2, 8'h03, 24'hA1B2C3, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0, 32'h00000000, 1'b0}, // R2 drop invalid
    '{4'd2, 8'h01, 24'hA1B2C3, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h00A1B2C3, 1'b0}, // R2 keep invalid
    '{4'd2, 8'h03, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h00A1B2C3, 1'b0}, // R2 valid passes
    '{4'd7, 8'h81, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0, 32'h00000000, 1'b0}, // R7 drop block start
    '{4'd7, 8'h01, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1, 32'h00A1B2C3, 1'b0}, // R7 keep block start
    '{4'd3, 8'h01, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0, 32'h00000000, 1'b1}, // R3 bad parity
    '{4'd3, 8'h09, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1, 32'h00A1B2C3, 1'b0}, // R3 parity ignored
    '{4'd1, 8'h00, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 32'h00000000, 1'b0}, // R1 off
    '{4'd1, 8'h00, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0, 32'h00000000, 1'b0}, // R1 off, bad parity
    '{4'd6, 8'h41, 24'hA1B2C3, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 32'h00A1B2C3, 1'b0}, // R6 pack at 24 ignored
    '{4'd3, 8'h01, 24'h123456, 1'b0,1'b1,1'b1,1'b0,1'b0, 1'b1, 32'h00123456, 1'b0}  // R3 U and C in parity
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] a, input logic v, input logic u, input logic c,
                      input logic blk, input logic badp, input logic rd);
    @(negedge clk);
    sf_valid_i = 1'b1; sf_audio_i = a; sf_v_i = v; sf_u_i = u; sf_c_i = c;
    sf_blk_i = blk; sf_p_i = (^{a, v, u, c}) ^ badp; hold_rd_i = rd;
    @(negedge clk);
    sf_valid_i = 1'b0; hold_rd_i = 1'b0;
  endtask

  task automatic swrst();
    @(negedge clk); soft_rst_i = 1'b1;
    @(negedge clk); soft_rst_i = 1'b0;
  endtask

  task automatic hold_read();
    @(negedge clk); hold_rd_i = 1'b1;
    @(negedge clk); hold_rd_i = 1'b0;
  endtask

  task automatic stat_read();
    @(negedge clk); stat_rd_i = 1'b1;
    @(negedge clk); stat_rd_i = 1'b0;
  endtask

  task automatic set_mode(input logic [7:0] m);
    @(negedge clk); mode_i = m;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 hold", hold_data_o, 32'h0);
    check("R12 flags", {29'b0, ready_o, overrun_o, par_err_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      swrst();
      set_mode(VECS[i].mode);
      send(VECS[i].audio, VECS[i].v, VECS[i].u, VECS[i].c, VECS[i].blk, VECS[i].badp, 1'b0);
      if (ready_o !== VECS[i].ld) begin
        errors++;
        $display("FAIL R%0d vec %0d ready: actual %b expected %b", VECS[i].req, i, ready_o, VECS[i].ld);
      end
      checks++;
      if (hold_data_o !== VECS[i].word) begin
        errors++;
        $display("FAIL R%0d vec %0d word: actual %h expected %h", VECS[i].req, i, hold_data_o, VECS[i].word);
      end
      checks++;
      if (par_err_o !== VECS[i].pe) begin
        errors++;
        $display("FAIL R%0d vec %0d parity flag: actual %b expected %b", VECS[i].req, i, par_err_o, VECS[i].pe);
      end
      checks++;
    end

    // R6 packing, little endian
    swrst();
    set_mode(8'h61);
    send(24'hA1B2C3, 0, 0, 0, 0, 0, 0);
    check("R6 first half not ready", {31'b0, ready_o}, 32'h0);
    send(24'h556677, 0, 0, 0, 0, 0, 0);
    check("R6 pair ready", {31'b0, ready_o}, 32'h1);
    check("R6 pair word", hold_data_o, 32'h5566A1B2);
    // R6 with R5 big endian halves
    hold_read();
    set_mode(8'h65);
    send(24'hA1B2C3, 0, 0, 0, 0, 0, 0);
    send(24'h556677, 0, 0, 0, 0, 0, 0);
    check("R6 big pair word", hold_data_o, 32'h6655B2A1);

    // R11 soft reset drops a pending half
    swrst();
    set_mode(8'h61);
    send(24'h111100, 0, 0, 0, 0, 0, 0);
    swrst();
    send(24'h222200, 0, 0, 0, 0, 0, 0);
    send(24'h333300, 0, 0, 0, 0, 0, 0);
    check("R11 half dropped", hold_data_o, 32'h33332222);
    // R1 turning off drops a pending half
    hold_read();
    send(24'h444400, 0, 0, 0, 0, 0, 0);
    set_mode(8'h60);
    set_mode(8'h61);
    send(24'h555500, 0, 0, 0, 0, 0, 0);
    check("R1 off drops half", {31'b0, ready_o}, 32'h0);
    send(24'h666600, 0, 0, 0, 0, 0, 0);
    check("R1 off drops half word", hold_data_o, 32'h66665555);

    // R9 overrun and overwrite
    swrst();
    set_mode(8'h01);
    send(24'h0000AA, 0, 0, 0, 0, 0, 0);
    send(24'h0000BB, 0, 0, 0, 0, 0, 0);
    check("R9 overrun set", {31'b0, overrun_o}, 32'h1);
    check("R9 overwritten", hold_data_o, 32'h000000BB);
    stat_read();
    check("R9 status read clears", {31'b0, overrun_o}, 32'h0);
    check("R8 ready kept over status read", {31'b0, ready_o}, 32'h1);
    // R8 load with simultaneous read
    send(24'h0000CC, 0, 0, 0, 0, 0, 1);
    check("R8 ready stays on load+read", {31'b0, ready_o}, 32'h1);
    check("R9 no overrun on load+read", {31'b0, overrun_o}, 32'h0);
    check("R8 word on load+read", hold_data_o, 32'h000000CC);
    hold_read();
    check("R8 read clears ready", {31'b0, ready_o}, 32'h0);

    // R10 sticky parity error
    send(24'h0000DD, 0, 0, 0, 0, 1, 0);
    send(24'h0000EE, 0, 0, 0, 0, 0, 0);
    check("R10 parity flag sticky", {31'b0, par_err_o}, 32'h1);
    check("R10 good sample loads", hold_data_o, 32'h000000EE);
    stat_read();
    check("R10 status read clears", {31'b0, par_err_o}, 32'h0);

    // R11 soft reset clears everything
    send(24'h0000FF, 0, 0, 0, 0, 1, 0);
    send(24'h000011, 0, 0, 0, 0, 0, 0);
    send(24'h000022, 0, 0, 0, 0, 0, 0);
    swrst();
    check("R11 hold cleared", hold_data_o, 32'h0);
    check("R11 flags cleared", {29'b0, ready_o, overrun_o, par_err_o}, 32'h0);

    finish_run();
  end
endmodule